// File: doc/BRIEF.md
# Small-Page NAND Read Command and Address Sequencer

This block turns a linear byte address in the main area of a small-page NAND array into the bus sequence that opens a page read. The array has 512 main bytes per page. In the linear address, bits 0 to 7 give the column, bit 8 picks the half of the page, and the bits above that give the page index. The block writes one command byte and then three address bytes on an 8-bit bus. Each byte is latched by a rising write strobe, with command-latch or address-latch enable set as needed.

Bit 8 of the address never appears on the bus. The block encodes it in the read opcode instead: 00h selects the lower 256-byte half and 01h selects the upper half. The three address bytes then carry the column byte and the 15-bit page index, and the top bit of the last byte is zero.

A request is presented with a valid/ready handshake. The block raises a single-clock done pulse when the sequence is complete. A page index past the last page (32768 pages) is refused with a single-clock error pulse, and the bus stays idle.

Top module: `nand_cmd_addr_seq`

## Requirements
- R1: The first bus byte is the read opcode: 8'h00 when address bit 8 is 0, 8'h01 when it is 1. It is sent with cmd_latch high and addr_latch low.
- R2: The second bus byte carries address bits 7..0 (bus bit i = address bit i), with addr_latch high and cmd_latch low.
- R3: The third bus byte carries address bits 16..9 (bus bit i = address bit 9+i), with addr_latch high.
- R4: The fourth bus byte carries address bits 23..17 on bus bits 6..0 (bus bit i = address bit 17+i), and bus bit 7 is 0.
- R5: Each byte uses two clocks. In the first, we_n is low. In the second, we_n is high. The data byte and the latch enables do not change across the rising edge of we_n.
- R6: ce_n is low from the first write-low clock through the last write-high clock. In the clock that follows, done is high for one clock and ce_n is high.
- R7: If the page index (address bits 25..9) is 32768 or more, err is high for one clock in the clock after the handshake, and ce_n, we_n, cmd_latch and addr_latch stay idle.
- R8: req_ready is low for the whole sequence, so a request held valid during a sequence is not taken. req_ready is high again in the done clock. A request held valid then is accepted at once, and its command byte follows in the next clock.
- R9: After reset: req_ready=1, ce_n=1, we_n=1, cmd_latch=0, addr_latch=0, done=0, err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 26 | Linear main-area byte address |
| done | output | 1 | One-clock pulse after the last address byte |
| err | output | 1 | One-clock pulse for an out-of-range page |
| ce_n | output | 1 | Device select, active low |
| cmd_latch | output | 1 | Command latch enable |
| addr_latch | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, byte latched on its rising edge |
| dq | output | 8 | Bus byte |

## Verification
The done pulse and the acceptance of the next request can happen in the same clock, because req_ready comes back during the done clock. The bench provokes this by raising req_valid with a second address early in a sequence and keeping it raised. It then checks two things. First, nothing is accepted while the first sequence runs, and the first sequence still carries its own latched address. Second, the second sequence begins in the clock right after done, with the opcode for the second address. The same back-to-back chaining follows an error pulse, to show that a refused request leaves the handshake idle.

// File: rtl/nand_cmd_addr_seq.sv
module nand_cmd_addr_seq #(
  parameter int ROW_W = 17,
  parameter int PAGES = 32768
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ROW_W+8:0]     req_addr,
  output logic                 done,
  output logic                 err,
  output logic                 ce_n,
  output logic                 cmd_latch,
  output logic                 addr_latch,
  output logic                 we_n,
  output logic [7:0]           dq
);
  localparam int AW = ROW_W + 9;

  logic        busy, ph;
  logic [1:0]  cyc;
  logic [23:0] a;
  logic        done_q, err_q;

  wire [ROW_W-1:0] row = req_addr[AW-1:9];
  wire bad  = {1'b0, row} >= (ROW_W+1)'(PAGES);
  wire take = req_valid && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ph <= 1'b0; cyc <= 2'd0; a <= '0;
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (busy) begin
        if (ph) begin
          ph  <= 1'b0;
          cyc <= cyc + 2'd1;
          if (cyc == 2'd3) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end else begin
          ph <= 1'b1;
        end
      end else if (take) begin
        if (bad) begin
          err_q <= 1'b1;
        end else begin
          busy <= 1'b1;
          ph   <= 1'b0;
          cyc  <= 2'd0;
          a    <= req_addr[23:0];
        end
      end
    end
  end

  always_comb begin
    case (cyc)
      2'd0:    dq = {7'b0, a[8]};
      2'd1:    dq = a[7:0];
      2'd2:    dq = a[16:9];
      default: dq = {1'b0, a[23:17]};
    endcase
  end

  assign req_ready  = !busy;
  assign ce_n       = !busy;
  assign we_n       = !(busy && !ph);
  assign cmd_latch  = busy && (cyc == 2'd0);
  assign addr_latch = busy && (cyc != 2'd0);
  assign done       = done_q;
  assign err        = err_q;

  a_r1_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_latch && addr_latch));

  a_r5_hold_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n) && !ce_n) |-> ($stable(dq) && $stable(cmd_latch) && $stable(addr_latch)));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(addr_latch) && $past(we_n) && ce_n));

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ce_n && we_n && !done && !$past(busy)));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !req_ready);

  a_r4_top_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_latch && $past(addr_latch) && $past(addr_latch, 2) && $past(addr_latch, 3)
     && !we_n) |-> !dq[7]);
endmodule

// File: tb/test_nand_cmd_addr_seq.sv
module test_nand_cmd_addr_seq;
  logic clk = 0, rst_n = 0, req_valid = 0;
  logic [25:0] req_addr = '0;
  logic req_ready, done, err, ce_n, cmd_latch, addr_latch, we_n;
  logic [7:0] dq;
  int checks = 0, errors = 0, cycles = 0;

  nand_cmd_addr_seq i_nand_cmd_addr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .done(done), .err(err), .ce_n(ce_n),
    .cmd_latch(cmd_latch), .addr_latch(addr_latch), .we_n(we_n), .dq(dq));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int k, input logic [25:0] ad);
    int col  = ad % 256;
    int half = (ad / 256) % 2;
    int row  = ad / 512;
    case (k)
      0: return 8'(half);
      1: return 8'(col);
      2: return 8'(row % 256);
      default: return 8'(row / 256);
    endcase
  endfunction

  task automatic start(input logic [25:0] ad);
    @(negedge clk); req_valid = 1; req_addr = ad;
    @(negedge clk); req_valid = 0;
  endtask

  // At entry: negedge of the first write-low clock of a sequence for ad.
  task automatic expect_seq(input logic [25:0] ad, input bit chain, input logic [25:0] nad);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] e = exp_byte(k, ad);
      string rq = (k == 0) ? "R1" : (k == 1) ? "R2" : (k == 2) ? "R3" : "R4";
      chk(dq === e, rq, dq, e);
      chk(we_n === 0 && ce_n === 0, "R5 R6 low phase", {ce_n, we_n}, 0);
      chk(cmd_latch === (k == 0) && addr_latch === (k != 0), rq, {cmd_latch, addr_latch},
          (k == 0) ? 2 : 1);
      chk(req_ready === 0, "R8", req_ready, 0);
      if (k == 0 && chain) begin req_valid = 1; req_addr = nad; end
      @(negedge clk);
      chk(we_n === 1 && ce_n === 0 && dq === e, "R5 high phase", dq, e);
      chk(cmd_latch === (k == 0) && addr_latch === (k != 0), "R5 latch hold",
          {cmd_latch, addr_latch}, (k == 0) ? 2 : 1);
      chk(done === 0, "R6 early", done, 0);
      @(negedge clk);
    end
    chk(done === 1 && ce_n === 1 && req_ready === 1, "R6 R8 done clock",
        {done, ce_n, req_ready}, 7);
    if (chain) begin
      @(negedge clk); req_valid = 0;
    end else begin
      @(negedge clk);
      chk(done === 0 && ce_n === 1, "R6 single pulse", {done, ce_n}, 1);
    end
  endtask

  task automatic expect_err(input logic [25:0] ad);
    start(ad);
    chk(err === 1 && ce_n === 1 && we_n === 1 && !cmd_latch && !addr_latch, "R7",
        {err, ce_n, we_n, cmd_latch, addr_latch}, 5'b11100);
    @(negedge clk);
    chk(err === 0 && ce_n === 1 && req_ready === 1, "R7 pulse", {err, ce_n, req_ready}, 3);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [25:0] pats[$];
    repeat (3) @(negedge clk);
    chk(req_ready === 1 && ce_n === 1 && we_n === 1 && !cmd_latch && !addr_latch
        && !done && !err, "R9", {req_ready, ce_n, we_n, cmd_latch, addr_latch, done, err},
        7'b1110000);
    rst_n = 1;
    pats.push_back(26'd0);
    for (int b = 0; b < 24; b++) pats.push_back(26'(1) << b);
    pats.push_back(26'hFFFFFF);
    pats.push_back(26'hA5A5A5);
    pats.push_back(26'h5A5A5A);
    pats.push_back(26'(32767 * 512 + 511));
    foreach (pats[i]) begin
      start(pats[i]);
      expect_seq(pats[i], 0, 0);
    end
    // R8: request held during a sequence, accepted in the done clock
    start(26'h123456);
    expect_seq(26'h123456, 1, 26'h0ABCDE);
    expect_seq(26'h0ABCDE, 1, 26'h7FFF01);
    expect_seq(26'h7FFF01, 0, 0);
    // R7: out-of-range pages
    expect_err(26'(32768 * 512));
    expect_err(26'h3FFFFFF);
    expect_err(26'(40000 * 512 + 3));
    start(26'h000100);
    expect_seq(26'h000100, 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule